// File: doc/BRIEF.md
# Bitstream Sync Header Detector

This block watches a byte-wide stream that carries a configuration image and looks for the fixed 13-word preamble that opens such an image. The preamble may begin at any byte offset from the start of the buffer. The block also works out by itself whether each 32-bit word of the stream arrives most-significant byte first or byte-reversed. The start of a buffer is flagged by a marker on its first byte. From that byte on, the block keeps a sliding window of the most recent 52 bytes. After each new byte it tests the window's oldest byte position as a possible preamble start, so moving on to the next offset never needs the upstream source to send bytes again.

When the preamble is found, a one-cycle pulse reports the byte offset where it starts and the detected byte order. From then on, every four following bytes are packed into a 32-bit word in that order and presented with a one-cycle valid strobe. If no preamble starts inside the configured scan window, a one-cycle not-found pulse is raised instead and the rest of the buffer is ignored. An abort input clears all state at once. The source must never stall, and the block itself only refuses bytes while abort is high.

Top module: `hdr_sync_detect`

## Requirements
- R1: The preamble is thirteen words: eight of 32'hFFFFFFFF, then 32'h000000BB, then 32'h11220044, then two of 32'hFFFFFFFF, and last 32'hAA995566. In normal order a word takes four consecutive bytes with the earliest byte as bits 31:24. A buffer holding this preamble in normal order raises `found` with `swapped` = 0.
- R2: In reversed order the earliest byte of each word is bits 7:0. A preamble sent that way raises `found` with `swapped` = 1. `swapped` and `found_offset` keep their values until the next start-of-buffer byte or abort, and both read 0 after one.
- R3: Each candidate is checked in normal order first. At the first word whose byte-reversed value is not 32'hFFFFFFFF and equals the expected word, the check switches to reversed order and compares every later word only in reversed order. An all-ones word never causes the switch, and a later word that matches only in normal order fails the candidate.
- R4: The preamble is detected at any byte offset, aligned or not. `found_offset` gives that offset counted from the start-of-buffer byte, which is offset 0.
- R5: A candidate is tried only where four bytes read 32'hFFFFFFFF. When a candidate fails, the next byte offset is tried, so surplus all-ones bytes before the preamble still give the correct offset.
- R6: Only offsets 0 to SCAN_LIMIT-1 are accepted. If the candidate at SCAN_LIMIT-1 fails, `not_found` pulses for one cycle and `found` never rises for that buffer. `found` and `not_found` are never high together.
- R7: After `found`, each group of four accepted bytes is emitted on `word_data` in the detected order with a one-cycle `word_valid`. The first group is the four bytes that directly follow the preamble.
- R8: Bytes accepted before any start-of-buffer byte are ignored. A start-of-buffer byte in any state restarts the search with itself at offset 0.
- R9: While `abort` is high, `in_ready` is low. Abort returns the block to its idle state, so later bytes without a new start-of-buffer marker raise no `found`, `not_found` or `word_valid`.
- R10: `found`, `found_offset` and `swapped` appear in the cycle after the clock edge that accepts the last preamble byte, and `found` is high for exactly one cycle. `not_found` appears in the cycle after the edge that accepts byte offset SCAN_LIMIT+50.
- R11: After `not_found`, further bytes raise no `found` and no `word_valid` until the next start-of-buffer byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abort | input | 1 | Clears all state; holds in_ready low |
| in_valid | input | 1 | Byte present on in_data |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| in_data | input | 8 | Stream byte |
| in_sob | input | 1 | Marks the first byte of a buffer |
| found | output | 1 | One-cycle preamble-found pulse |
| found_offset | output | OFF_W | Byte offset of the preamble start |
| swapped | output | 1 | Detected order: 1 = byte-reversed words |
| not_found | output | 1 | One-cycle pulse: scan window used up |
| word_valid | output | 1 | One-cycle strobe for word_data |
| word_data | output | 32 | Word reassembled in the detected order |

## Verification
`in_ready` follows `abort` in the same cycle. Every other result is registered and is due in the cycle after the edge that accepts the byte deciding it. For `found`, `found_offset` and `swapped` that byte is the last preamble byte. For `not_found` it is byte offset SCAN_LIMIT+50, and for `word_valid` it is the fourth byte of a group. The bench's behavioural model updates its expected values on the same rising edge, from the byte accepted at that edge. Inputs change one nanosecond after a rising edge, and outputs are compared with the model at the falling edge, when both have settled. Scenario totals (pulse counts, offset, order, words) are checked a few idle cycles after the last byte, once every due result has appeared.

// File: rtl/hdr_sync_pkg.sv
package hdr_sync_pkg;

    localparam int unsigned HDR_WORDS = 13;
    localparam int unsigned HDR_BYTES = 4 * HDR_WORDS;
    localparam logic [31:0] FILL_WORD = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_STREAM = 2'd2,
        ST_DONE   = 2'd3
    } scan_state_e;

    // Expected preamble word at word position idx (normal order).
    function automatic logic [31:0] hdr_pattern(input int unsigned idx);
        logic [31:0] w;
        case (idx)
            8:       w = 32'h0000_00BB;
            9:       w = 32'h1122_0044;
            12:      w = 32'hAA99_5566;
            default: w = FILL_WORD;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/hdr_window.sv
// Sliding byte window; byte 0 (LSB) is the oldest, new bytes enter at the top.
module hdr_window #(
    parameter int unsigned DEPTH = 52
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift,
    input  logic [7:0]         din,
    output logic [8*DEPTH-1:0] win_d,
    output logic [8*DEPTH-1:0] win_q
);

    logic [8*DEPTH-1:0] shifted;

    for (genvar k = 0; k < DEPTH; k++) begin : g_lane
        if (k == DEPTH - 1) begin : g_top
            assign shifted[8*k +: 8] = din;
        end else begin : g_mid
            assign shifted[8*k +: 8] = win_q[8*(k+1) +: 8];
        end
    end

    always_comb begin
        win_d = win_q;
        if (clr) begin
            win_d = '0;
        end else if (shift) begin
            win_d = shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

endmodule

// File: rtl/hdr_match.sv
// Combinational preamble test over a full window with byte-order decision chain.
module hdr_match
    import hdr_sync_pkg::*;
#(
    parameter int unsigned NWORDS = HDR_WORDS
) (
    input  logic [32*NWORDS-1:0] win,
    output logic                 hit,
    output logic                 rev_order
);

    logic [NWORDS:0]   sw;
    logic [NWORDS-1:0] ok;

    assign sw[0] = 1'b0;

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        localparam logic [31:0] EXP = hdr_pattern(i);
        logic [31:0] fwd;
        logic [31:0] bwd;
        logic        flip;

        // Earliest byte sits lowest in the window.
        assign fwd  = {win[32*i +: 8], win[32*i+8 +: 8],
                       win[32*i+16 +: 8], win[32*i+24 +: 8]};
        assign bwd  = win[32*i +: 32];
        assign flip = !sw[i] && (bwd != FILL_WORD) && (bwd == EXP);
        assign sw[i+1] = sw[i] | flip;
        assign ok[i]   = sw[i+1] ? (bwd == EXP) : (fwd == EXP);
    end

    assign hit       = &ok;
    assign rev_order = sw[NWORDS];

endmodule

// File: rtl/word_pack.sv
// Packs bytes into words in normal or reversed order.
module word_pack #(
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    load,
    input  logic                    rev,
    input  logic [7:0]              din,
    output logic                    vld,
    output logic [8*WORD_BYTES-1:0] data
);

    localparam int unsigned W  = 8 * WORD_BYTES;
    localparam int unsigned CW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  acc;
        logic          vld;
        logic [W-1:0]  data;
    } pack_t;

    pack_t p_d, p_q;
    logic [W-1:0] nacc;

    always_comb begin
        p_d     = p_q;
        p_d.vld = 1'b0;
        nacc    = rev ? {din, p_q.acc[W-1:8]} : {p_q.acc[W-9:0], din};
        if (clr) begin
            p_d = '0;
        end else if (load) begin
            p_d.acc = nacc;
            if (p_q.cnt == CW'(WORD_BYTES - 1)) begin
                p_d.vld  = 1'b1;
                p_d.data = nacc;
                p_d.cnt  = '0;
            end else begin
                p_d.cnt = p_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign vld  = p_q.vld;
    assign data = p_q.data;

endmodule

// File: rtl/hdr_sync_detect.sv
module hdr_sync_detect
    import hdr_sync_pkg::*;
#(
    parameter int unsigned SCAN_LIMIT = 256,
    localparam int unsigned OFF_W = (SCAN_LIMIT > 1) ? $clog2(SCAN_LIMIT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sob,
    output logic             found,
    output logic [OFF_W-1:0] found_offset,
    output logic             swapped,
    output logic             not_found,
    output logic             word_valid,
    output logic [31:0]      word_data
);

    localparam int unsigned CNT_W = $clog2(SCAN_LIMIT + HDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_OFF = CNT_W'(SCAN_LIMIT - 1);

    typedef struct packed {
        scan_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             found;
        logic             nfound;
        logic [OFF_W-1:0] off;
        logic             swp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                   accept;
    logic                   start;
    logic [CNT_W-1:0]       idx;
    logic [CNT_W-1:0]       cand;
    logic                   hit;
    logic                   hit_rev;
    logic                   pk_load;
    logic                   pk_clr;
    logic [8*HDR_BYTES-1:0] win_next;
    logic [8*HDR_BYTES-1:0] win_now;

    assign in_ready = !abort;
    assign accept   = in_valid && !abort;
    assign start    = accept && in_sob;
    assign idx      = start ? '0 : ctl_q.cnt;
    assign cand     = idx - LAST_IDX;

    hdr_window #(.DEPTH(HDR_BYTES)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (abort),
        .shift (accept),
        .din   (in_data),
        .win_d (win_next),
        .win_q (win_now)
    );

    hdr_match #(.NWORDS(HDR_WORDS)) u_match (
        .win       (win_next),
        .hit       (hit),
        .rev_order (hit_rev)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.found  = 1'b0;
        ctl_d.nfound = 1'b0;
        if (abort) begin
            ctl_d = '0;
        end else if (accept && (start || ctl_q.st == ST_SCAN)) begin
            ctl_d.st  = ST_SCAN;
            ctl_d.cnt = idx + 1'b1;
            if (start) begin
                ctl_d.swp = 1'b0;
                ctl_d.off = '0;
            end
            if (idx >= LAST_IDX) begin
                if (hit) begin
                    ctl_d.found = 1'b1;
                    ctl_d.off   = OFF_W'(cand);
                    ctl_d.swp   = hit_rev;
                    ctl_d.st    = ST_STREAM;
                end else if (cand == LAST_OFF) begin
                    ctl_d.nfound = 1'b1;
                    ctl_d.st     = ST_DONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pk_load = accept && !in_sob && (ctl_q.st == ST_STREAM);
    assign pk_clr  = abort || start;

    word_pack #(.WORD_BYTES(4)) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pk_clr),
        .load  (pk_load),
        .rev   (ctl_q.swp),
        .din   (in_data),
        .vld   (word_valid),
        .data  (word_data)
    );

    assign found        = ctl_q.found;
    assign not_found    = ctl_q.nfound;
    assign found_offset = ctl_q.off;
    assign swapped      = ctl_q.swp;

    logic unused_win;
    assign unused_win = ^win_now;

endmodule

// File: rtl/hdr_sync_chk.sv
module hdr_sync_chk (
    input logic clk,
    input logic rst_n,
    input logic abort,
    input logic in_valid,
    input logic in_ready,
    input logic in_sob,
    input logic found,
    input logic not_found,
    input logic swapped,
    input logic word_valid
);

    logic seen_q;
    logic sob_acc;

    assign sob_acc = in_valid && in_ready && in_sob;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (abort || sob_acc) begin
            seen_q <= 1'b0;
        end else if (found) begin
            seen_q <= 1'b1;
        end
    end

    // R10
    found_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> !found);

    // R6
    nf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_found |=> !not_found);

    // R6
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && not_found));

    // R9
    abort_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !in_ready);

    // R7
    word_after_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> seen_q);

    // R2
    swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort && !sob_acc) |=> ($stable(swapped) || found));

endmodule

bind hdr_sync_detect hdr_sync_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (abort),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_sob     (in_sob),
    .found      (found),
    .not_found  (not_found),
    .swapped    (swapped),
    .word_valid (word_valid)
);

// File: tb/tb_hdr_sync_detect.sv
`timescale 1ns/1ps
module tb_hdr_sync_detect;

    localparam int SL = 16;
    localparam int OW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic abort = 1'b0;
    logic in_valid = 1'b0;
    logic in_sob = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, found, swapped, not_found, word_valid;
    logic [OW-1:0] found_offset;
    logic [31:0] word_data;

    always #4 clk = ~clk;

    hdr_sync_detect #(.SCAN_LIMIT(SL)) dut (
        .clk(clk), .rst_n(rst_n), .abort(abort), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_sob(in_sob),
        .found(found), .found_offset(found_offset), .swapped(swapped),
        .not_found(not_found), .word_valid(word_valid), .word_data(word_data)
    );

    int checks = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mst = 0;               // 0 idle, 1 scan, 2 stream, 3 done
    logic [7:0] mq[$];
    bit e_found = 0, e_nf = 0, e_swp = 0, e_wv = 0;
    int e_off = 0;
    logic [31:0] e_wd = 0;
    logic [31:0] pk_acc = 0;
    int pk_n = 0;

    function automatic logic [31:0] pat(input int i);
        if (i == 8) return 32'h0000_00BB;
        if (i == 9) return 32'h1122_0044;
        if (i == 12) return 32'hAA99_5566;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic bit hdr_ok(input int s, output bit sw);
        logic [31:0] n, r;
        sw = 0;
        for (int i = 0; i < 13; i++) begin
            n = {mq[s+4*i], mq[s+4*i+1], mq[s+4*i+2], mq[s+4*i+3]};
            r = {mq[s+4*i+3], mq[s+4*i+2], mq[s+4*i+1], mq[s+4*i]};
            if (!sw) begin
                if (r != 32'hFFFF_FFFF && r == pat(i)) sw = 1;
                else if (n != pat(i)) return 0;
            end else if (r != pat(i)) return 0;
        end
        return 1;
    endfunction

    always @(posedge clk) begin
        bit sw;
        int j;
        e_found = 0; e_nf = 0; e_wv = 0;
        if (!rst_n || abort) begin
            mst = 0; e_swp = 0; e_off = 0; pk_n = 0; mq.delete();
        end else if (in_valid) begin
            if (in_sob) begin
                mq.delete(); mst = 1; e_swp = 0; e_off = 0; pk_n = 0;
            end
            if (mst == 1) begin
                mq.push_back(in_data);
                j = mq.size() - 1;
                if (j >= 51) begin
                    if (hdr_ok(j - 51, sw)) begin
                        e_found = 1; e_off = j - 51; e_swp = sw; mst = 2; pk_n = 0;
                    end else if (j - 51 == SL - 1) begin
                        e_nf = 1; mst = 3;
                    end
                end
            end else if (mst == 2 && !in_sob) begin
                pk_acc = e_swp ? {in_data, pk_acc[31:8]} : {pk_acc[23:0], in_data};
                pk_n++;
                if (pk_n == 4) begin
                    e_wv = 1; e_wd = pk_acc; pk_n = 0;
                end
            end
        end
    end

    // ---------------- monitor: per-cycle comparison ----------------
    int found_n = 0, nf_n = 0, wv_n = 0, last_off = -1;
    bit last_swp = 0;
    logic [31:0] gotw[$];

    always @(negedge clk) begin
        if (rst_n) begin
            chk(in_ready == !abort, "R9", "in_ready", in_ready, !abort);
            chk(found == e_found, "R10", "found", found, e_found);
            chk(not_found == e_nf, "R6", "not_found", not_found, e_nf);
            chk(swapped == e_swp, "R2", "swapped", swapped, e_swp);
            chk(int'(found_offset) == e_off, "R4", "found_offset", found_offset, e_off);
            chk(word_valid == e_wv, "R7", "word_valid", word_valid, e_wv);
            if (e_wv) chk(word_data == e_wd, "R7", "word_data", word_data, e_wd);
            if (found) begin found_n++; last_off = found_offset; last_swp = swapped; end
            if (not_found) nf_n++;
            if (word_valid) begin wv_n++; gotw.push_back(word_data); end
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic put(input logic [7:0] b, input bit sob);
        in_valid = 1; in_data = b; in_sob = sob;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        in_valid = 0; in_sob = 0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic clear_mon();
        found_n = 0; nf_n = 0; wv_n = 0; last_off = -1; last_swp = 0;
        gotw.delete();
    endtask

    // mode 0 normal, 1 reversed, 2 reversed up to word 8 then word 9 normal,
    // 3 normal up to word 8 then reversed
    task automatic send_hdr(input int mode, input bit first_sob);
        logic [31:0] w;
        bit rv;
        for (int i = 0; i < 13; i++) begin
            w = pat(i);
            rv = (mode == 1) || (mode == 2 && i != 9) || (mode == 3 && i >= 9);
            for (int k = 0; k < 4; k++) begin
                if (rv) put(w[8*k +: 8], first_sob && i == 0 && k == 0);
                else    put(w[31-8*k -: 8], first_sob && i == 0 && k == 0);
            end
        end
    endtask

    task automatic send_data8();
        for (int k = 1; k <= 8; k++) put(8'(k), 0);
    endtask

    task automatic summary_checks(input string req, input int fn, input int nn,
                                  input int off, input int swp);
        chk(found_n == fn, req, "found count", found_n, fn);
        chk(nf_n == nn, req, "not_found count", nf_n, nn);
        if (fn > 0) begin
            chk(last_off == off, req, "offset", last_off, off);
            chk(last_swp == swp, req, "order", last_swp, swp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(found == 0 && not_found == 0 && word_valid == 0, "R1", "reset outputs",
            {found, not_found, word_valid}, 0);
        chk(swapped == 0 && found_offset == 0, "R2", "reset order/offset",
            {swapped, found_offset}, 0);
        chk(in_ready == 1, "R9", "reset in_ready", in_ready, 1);
        @(posedge clk); #1;

        // R8: bytes before any start marker are ignored
        clear_mon();
        send_hdr(0, 0); send_data8(); idle(4);
        summary_checks("R8", 0, 0, 0, 0);
        chk(wv_n == 0, "R8", "words before sob", wv_n, 0);

        // R1 / R7: normal order at offset 0
        clear_mon();
        send_hdr(0, 1); send_data8(); idle(4);
        summary_checks("R1", 1, 0, 0, 0);
        chk(wv_n == 2, "R7", "word count normal", wv_n, 2);
        if (wv_n == 2) begin
            chk(gotw[0] == 32'h01020304, "R7", "word0 normal", gotw[0], 32'h01020304);
            chk(gotw[1] == 32'h05060708, "R7", "word1 normal", gotw[1], 32'h05060708);
        end

        // R2 / R4 / R7: reversed order at unaligned offset 3
        clear_mon();
        put(8'h12, 1); put(8'hFF, 0); put(8'hFF, 0);
        send_hdr(1, 0); send_data8(); idle(4);
        summary_checks("R4", 1, 0, 3, 1);
        chk(wv_n == 2, "R7", "word count reversed", wv_n, 2);
        if (wv_n == 2) begin
            chk(gotw[0] == 32'h04030201, "R2", "word0 reversed", gotw[0], 32'h04030201);
            chk(gotw[1] == 32'h08070605, "R2", "word1 reversed", gotw[1], 32'h08070605);
        end

        // R2 / R8: new start marker clears order
        put(8'h00, 1); idle(2);
        chk(swapped == 0, "R2", "order cleared by sob", swapped, 0);

        // R5: surplus all-ones bytes before the preamble
        clear_mon();
        for (int k = 0; k < 4; k++) put(8'hFF, k == 0);
        send_hdr(0, 0); idle(4);
        summary_checks("R5", 1, 0, 4, 0);

        // R3: switch to reversed, then a normal-only word fails
        clear_mon();
        send_hdr(2, 1);
        for (int k = 0; k < 28; k++) put(8'h00, 0);
        idle(4);
        summary_checks("R3", 0, 1, 0, 0);

        // R3: late switch at word 9 is accepted as reversed
        clear_mon();
        send_hdr(3, 1); idle(4);
        summary_checks("R3", 1, 0, 0, 1);

        // R6: last accepted offset
        clear_mon();
        for (int k = 0; k < SL - 1; k++) put(8'h00, k == 0);
        send_hdr(0, 0); idle(4);
        summary_checks("R6", 1, 0, SL - 1, 0);

        // R6 / R11: one past the window, then a header without sob
        clear_mon();
        for (int k = 0; k < SL; k++) put(8'h00, k == 0);
        send_hdr(0, 0);
        send_hdr(0, 0); send_data8(); idle(4);
        summary_checks("R6", 0, 1, 0, 0);
        chk(wv_n == 0, "R11", "no words after not_found", wv_n, 0);

        // R9: abort mid-preamble, remaining bytes without sob
        clear_mon();
        put(8'hFF, 1);
        for (int k = 1; k < 30; k++) put(8'hFF, 0);
        abort = 1; put(8'hFF, 0); put(8'hFF, 0); abort = 0;
        for (int k = 0; k < 22; k++) put(8'hFF, 0);
        send_hdr(0, 0); send_data8(); idle(4);
        summary_checks("R9", 0, 0, 0, 0);
        chk(wv_n == 0, "R9", "no words after abort", wv_n, 0);

        // R8: restart in the middle of a preamble
        clear_mon();
        for (int k = 0; k < 20; k++) put(8'hFF, k == 0);
        send_hdr(1, 1); send_data8(); idle(4);
        summary_checks("R8", 1, 0, 0, 1);
        chk(wv_n == 2, "R7", "words after restart", wv_n, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule